// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a two-port shared memory and decides what happens when both ports reach for the same word. Each port supplies an enable, a write strobe and an address. When both ports are enabled at one address, the block picks a winner and raises a busy flag toward the other port. It also uses that flag to hold back the losing port's write before the write reaches the array. The winner is the port whose request was already in place first. A request is in place when it was enabled at that same address in the previous cycle. When both ports arrive together, the left port takes priority.

The block runs on one clock. Busy is active low and comes from a register, so it appears one clock after the colliding request is sampled. A mode pin sets the role. In master mode the block makes the decision and drives both busy outputs. In slave mode the busy outputs stay high, and two busy inputs from an outside master act only as per-port write inhibits. This lets several blocks that share one address range share a single decision. All pins are plain control signals. None carries a data stream, so the block has no valid/ready handshake.

Top module: `dp_collision_arbiter`

## Requirements
- R1: In master mode, with no collision (one or both enables low, or the two addresses differ), both busy outputs are high.
- R2: Busy comes from a register: a collision sampled at clock edge k shows on the losing busy output just after edge k, never before it.
- R3: A port that was enabled at an unchanged address in the previous cycle wins against a port that has just arrived at that address. Only the port that arrived later sees busy low.
- R4: When both ports arrive in the same cycle, the left port wins and busy_r_n goes low. The two busy outputs are never low together.
- R5: While the collision lasts, the winner is kept, whatever either port's write strobe does and even if the loser drops and re-asserts nothing.
- R6: Busy returns high one clock after the addresses differ or either enable drops, as sampled at an edge.
- R7: The write strobes have no effect on the arbitration result.
- R8: In master mode a port's write enable to the array is ce AND we AND (its busy output high). The busy inputs are ignored.
- R9: In slave mode both busy outputs stay high, and a port's write enable is ce AND we AND (its busy input high). A busy input held low blocks every write from that port.
- R10: During and just after reset both busy outputs are high and no collision is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 = master (computes busy), 0 = slave (busy inputs inhibit) |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port address |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port address |
| busy_l_i_n | input | 1 | Slave-mode write inhibit for the left port, active low |
| busy_r_i_n | input | 1 | Slave-mode write inhibit for the right port, active low |
| busy_l_n | output | 1 | Left port busy, active low, registered |
| busy_r_n | output | 1 | Right port busy, active low, registered |
| l_wr_en | output | 1 | Gated left write enable to the array |
| r_wr_en | output | 1 | Gated right write enable to the array |

## Verification
The two functions that can fall in the same cycle are the arbitration decision and the write gate. The bench provokes this in four ways: a port writes in the very cycle it collides, both ports arrive together, a loser keeps writing through a held collision, and a winner writes while a late arrival lands on its address. In each of these cases the bench's reference model gives the expected busy levels and the expected gated write enables. The outputs are compared on every clock, so the first collision cycle is judged too. In that cycle the write must still pass, because busy is registered.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    W_NONE  = 2'd0,
    W_LEFT  = 2'd1,
    W_RIGHT = 2'd2
  } win_e;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L = 0;
  localparam int unsigned PORT_R = 1;
endpackage

// File: rtl/dpa_arrival.sv
module dpa_arrival #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [ADDR_W-1:0] addr,
  output logic              held
);
  logic              ce_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      ce_q   <= ce;
      addr_q <= addr;
    end
  end

  // Request already in place last cycle at the same address.
  assign held = ce && ce_q && (addr == addr_q);

  p_held_needs_past_r3: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> $past(ce));
endmodule

// File: rtl/dpa_decider.sv
module dpa_decider
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_held,
  input  logic              r_held,
  output win_e              winner_q
);
  logic coll;
  win_e win_d;

  assign coll = l_ce && r_ce && (l_addr == r_addr);

  always_comb begin
    win_d = winner_q;
    if (!coll) begin
      win_d = W_NONE;
    end else if (winner_q == W_NONE) begin
      win_d = (r_held && !l_held) ? W_RIGHT : W_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) winner_q <= W_NONE;
    else        winner_q <= win_d;
  end

  p_win_needs_coll_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (winner_q != W_NONE) |-> $past(coll));
  p_hold_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (winner_q != W_NONE && coll) |=> (winner_q == $past(winner_q)));
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !coll |=> (winner_q == W_NONE));
  p_early_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && winner_q == W_NONE && l_held && !r_held) |=> (winner_q == W_LEFT));
  p_early_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && winner_q == W_NONE && r_held && !l_held) |=> (winner_q == W_RIGHT));
endmodule

// File: rtl/dpa_write_gate.sv
module dpa_write_gate (
  input  logic master_mode,
  input  logic ce,
  input  logic we,
  input  logic lost,
  input  logic inh_in_n,
  output logic wr_en
);
  logic inhibit;

  assign inhibit = master_mode ? lost : !inh_in_n;
  assign wr_en   = ce && we && !inhibit;
endmodule

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              busy_l_i_n,
  input  logic              busy_r_i_n,
  output logic              busy_l_n,
  output logic              busy_r_n,
  output logic              l_wr_en,
  output logic              r_wr_en
);
  logic [NUM_PORTS-1:0]             ce_v, we_v, held_v, lost_v, inh_v, wr_v;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
  win_e                             winner_q;

  assign ce_v[PORT_L]   = l_ce;
  assign ce_v[PORT_R]   = r_ce;
  assign we_v[PORT_L]   = l_we;
  assign we_v[PORT_R]   = r_we;
  assign addr_v[PORT_L] = l_addr;
  assign addr_v[PORT_R] = r_addr;
  assign inh_v[PORT_L]  = busy_l_i_n;
  assign inh_v[PORT_R]  = busy_r_i_n;
  assign lost_v[PORT_L] = (winner_q == W_RIGHT);
  assign lost_v[PORT_R] = (winner_q == W_LEFT);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dpa_arrival #(.ADDR_W(ADDR_W)) u_arr (
      .clk  (clk),
      .rst_n(rst_n),
      .ce   (ce_v[p]),
      .addr (addr_v[p]),
      .held (held_v[p])
    );
    dpa_write_gate u_gate (
      .master_mode(master_mode),
      .ce         (ce_v[p]),
      .we         (we_v[p]),
      .lost       (lost_v[p]),
      .inh_in_n   (inh_v[p]),
      .wr_en      (wr_v[p])
    );
  end

  dpa_decider #(.ADDR_W(ADDR_W)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_ce    (l_ce),
    .l_addr  (l_addr),
    .r_ce    (r_ce),
    .r_addr  (r_addr),
    .l_held  (held_v[PORT_L]),
    .r_held  (held_v[PORT_R]),
    .winner_q(winner_q)
  );

  assign busy_l_n = !(master_mode && lost_v[PORT_L]);
  assign busy_r_n = !(master_mode && lost_v[PORT_R]);
  assign l_wr_en  = wr_v[PORT_L];
  assign r_wr_en  = wr_v[PORT_R];

  p_never_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!busy_l_n && !busy_r_n));
  p_busy_l_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !busy_l_n) |-> !l_wr_en);
  p_busy_r_gates_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && !busy_r_n) |-> !r_wr_en);
  p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (busy_l_n && busy_r_n));
  p_slave_inh_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !busy_l_i_n) |-> !l_wr_en);
endmodule

// File: tb/dp_collision_arbiter_tb.sv
module dp_collision_arbiter_tb;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          master_mode = 1'b1;
  logic          l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic          busy_l_i_n = 1, busy_r_i_n = 1;
  logic          busy_l_n, busy_r_n, l_wr_en, r_wr_en;

  int    n_cmp = 0, n_bad = 0;
  string tag = "R10";
  bit    done = 0;

  // reference model state
  int            m_win = 0; // 0 none, 1 left, 2 right
  bit            m_pl_ce = 0, m_pr_ce = 0;
  logic [AW-1:0] m_pl_a = '0, m_pr_a = '0;

  always #4 clk = ~clk;

  dp_collision_arbiter #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr),
    .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr),
    .busy_l_i_n(busy_l_i_n), .busy_r_i_n(busy_r_i_n),
    .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
    .l_wr_en(l_wr_en), .r_wr_en(r_wr_en)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit lh, rh, coll;
    lh   = l_ce && m_pl_ce && (l_addr == m_pl_a);
    rh   = r_ce && m_pr_ce && (r_addr == m_pr_a);
    coll = l_ce && r_ce && (l_addr == r_addr);
    if (!coll) m_win = 0;
    else if (m_win == 0) m_win = (rh && !lh) ? 2 : 1;
    m_pl_ce = l_ce; m_pr_ce = r_ce; m_pl_a = l_addr; m_pr_a = r_addr;
  endtask

  task automatic compare();
    logic el, er, wl, wr;
    el = !(master_mode && m_win == 2);
    er = !(master_mode && m_win == 1);
    wl = l_ce && l_we && (master_mode ? (m_win != 2) : busy_l_i_n);
    wr = r_ce && r_we && (master_mode ? (m_win != 1) : busy_r_i_n);
    chk(busy_l_n, el, "busy_l_n");
    chk(busy_r_n, er, "busy_r_n");
    chk(l_wr_en, wl, "l_wr_en");
    chk(r_wr_en, wr, "r_wr_en");
  endtask

  // Called at a negedge: apply inputs, clock once, compare at next negedge.
  task automatic cyc(input bit lc, input bit lw, input int la,
                     input bit rc, input bit rw, input int ra);
    l_ce = lc; l_we = lw; l_addr = AW'(la);
    r_ce = rc; r_we = rw; r_addr = AW'(ra);
    #1 compare(); // combinational write gate before the edge
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    tag = "R10";
    compare();
    rst_n = 1'b1;
    cyc(0,0,0, 0,0,0);

    // R1: no collision patterns
    tag = "R1";
    cyc(1,1,5, 1,1,6);
    cyc(1,0,7, 1,0,8);
    cyc(1,1,9, 0,1,9);
    cyc(0,1,9, 1,1,9);

    // R3/R2: left in place, right arrives late (right writes in first cycle)
    tag = "R3";
    cyc(1,0,20, 0,0,0);
    tag = "R2";
    cyc(1,0,20, 1,1,20);
    tag = "R5";
    cyc(1,1,20, 1,1,20);
    cyc(1,0,20, 1,1,20);
    tag = "R6";
    cyc(1,1,21, 1,1,20);
    cyc(0,0,0, 0,0,0);

    // R3: right first, left arrives late
    tag = "R3";
    cyc(0,0,0, 1,1,33);
    cyc(1,1,33, 1,1,33);
    cyc(1,1,33, 1,0,33);
    tag = "R6";
    cyc(1,1,33, 0,0,33);
    cyc(0,0,0, 0,0,0);

    // R4: same-cycle arrival, then hold
    tag = "R4";
    cyc(1,1,44, 1,1,44);
    cyc(1,1,44, 1,1,44);
    cyc(0,0,0, 0,0,0);

    // R7: write strobes must not change the outcome of a tie or late arrival
    tag = "R7";
    cyc(1,0,50, 1,1,50);
    cyc(1,0,50, 1,0,50);
    cyc(0,0,0, 0,0,0);
    cyc(0,0,0, 1,0,51);
    cyc(1,1,51, 1,0,51);
    cyc(0,0,0, 0,0,0);

    // R8: busy inputs ignored in master mode
    tag = "R8";
    busy_l_i_n = 0; busy_r_i_n = 0;
    cyc(1,1,60, 1,1,61);
    cyc(1,1,62, 1,1,62);
    cyc(1,1,62, 1,1,62);
    busy_l_i_n = 1; busy_r_i_n = 1;
    cyc(0,0,0, 0,0,0);

    // R9: slave mode
    tag = "R9";
    master_mode = 0;
    cyc(1,1,70, 1,1,70);
    cyc(1,1,70, 1,1,70);
    busy_l_i_n = 0;
    cyc(1,1,70, 1,1,71);
    cyc(1,1,72, 1,1,73);
    busy_l_i_n = 1; busy_r_i_n = 0;
    cyc(1,1,74, 1,1,74);
    busy_r_i_n = 1;
    cyc(1,1,74, 1,1,74);
    master_mode = 1;
    cyc(0,0,0, 0,0,0);

    // Mixed traffic over a tiny address space (R3, R5, R6, R7 together)
    tag = "R3";
    for (int i = 0; i < 400; i++) begin
      if (i == 300) master_mode = 0;
      busy_l_i_n = ($urandom % 4) != 0;
      busy_r_i_n = ($urandom % 4) != 0;
      cyc(($urandom % 4) != 0, $urandom % 2, $urandom % 3,
          ($urandom % 4) != 0, $urandom % 2, $urandom % 3);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule